// File: doc/BRIEF.md
# Two-Step Converter Interface Controller

This block is the digital timing and control section of an 8-bit, two-step (coarse then fine) multiplexed converter. One read strobe, with chip select and read both low, captures the channel address and starts a conversion. The comparators track the input for a set number of cycles. The coarse comparator bank is then sampled and encoded into the upper nibble. After a further set number of cycles the fine bank is sampled and encoded into the lower nibble, and this completes the result.

A processor sees the block as a memory location. In stretched-cycle mode the read is held low through the whole conversion. The open-drain ready line holds the bus cycle until the result reaches the data outputs. In pipelined mode every read returns the previous result at once and starts the next conversion, so no wait states are needed. The tri-state bus is modelled as a data vector plus an output enable. The open-drain ready line is modelled as a pull-low request.

Top module: `hf_adc_ctrl`

## Requirements
- R1: A conversion starts on the first clock edge at which chip select and read are both sampled low after at least one sample in which either was high, provided no conversion is running. At that edge the address is latched onto `ch_sel_o` as a one-hot vector: address value k sets bit k, which is channel k+1.
- R2: After a start, `track_o` is high for exactly TRACK_CYC cycles, and `coarse_stb_o` is high in the last of them. A fine phase of exactly FINE_CYC cycles follows, and `fine_stb_o` is high in its last cycle.
- R3: The result is {ones(coarse vector), ones(fine vector)}, upper nibble coarse, with each 15-bit vector sampled at the edge that ends its strobe cycle. Counting ones means a vector with bubbles still encodes to 0..15.
- R4: `int_no` goes low at the edge that ends the fine phase. It returns high at the first edge after a rising chip select or rising read is sampled. Completion wins when both happen at the same edge.
- R5: `rdy_pull_o` is set at the edge after chip select is sampled falling, and it is cleared at the edge after chip select is sampled rising. In stretched mode (`mode1_i`=0) it is also cleared at completion. A falling chip select takes priority.
- R6: In stretched mode, `data_oe_o` stays low during a conversion and rises at the completion edge if chip select and read are still both low. It then stays high until either of them is sampled high.
- R7: In pipelined mode (`mode1_i`=1), `data_oe_o` follows the combined select one edge later, and the bus shows the last completed result, not the one being converted.
- R8: A read strobe that arrives during a conversion neither restarts nor delays it, and it does not change the latched channel.
- R9: While `data_oe_o` is low, `data_o` is all zeros. After reset: `int_no`=1, `rdy_pull_o`=0, `data_oe_o`=0, result 0, `track_o`=0, and channel 1 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | AW | Channel address, AW = clog2(NUM_CH) |
| mode1_i | input | 1 | 0 = stretched cycle, 1 = pipelined read |
| coarse_therm_i | input | 15 | Coarse comparator bank outputs |
| fine_therm_i | input | 15 | Fine comparator bank outputs |
| ch_sel_o | output | NUM_CH | Latched one-hot channel select |
| track_o | output | 1 | Comparators tracking the input |
| coarse_stb_o | output | 1 | Coarse bank latch strobe |
| fine_stb_o | output | 1 | Fine bank latch strobe |
| data_o | output | 8 | Result, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| int_no | output | 1 | Conversion complete, active low |
| rdy_pull_o | output | 1 | Pull the ready line low |

## Verification
The bench compares a behavioural model against every output on every cycle. It targets these cases:
- A second read in the middle of a conversion. A design that restarts on it finishes late, and one that re-latches the address moves `ch_sel_o`.
- Bubbled thermometer vectors. A priority-style encoder would return the wrong nibble for these.
- Chip select falling a cycle before read. A design that ties ready to the combined select pulls ready one cycle late.
- Pipelined reads. The first bus value must be the earlier result. A design that shows the running conversion's half-built result, or that waits for completion, gives the wrong value or stalls.

// File: rtl/hf_adc_pkg.sv
package hf_adc_pkg;
  localparam int THERM_W = 15;
  localparam int NIB_W   = $clog2(THERM_W + 1);
  localparam int RES_W   = 2 * NIB_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_FINE  = 2'd2
  } phase_e;
endpackage

// File: rtl/hf_therm_enc.sv
// Population count: bubbles in the vector cannot push the code out of range.
module hf_therm_enc #(
  parameter int W  = 15,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm_i,
  output logic [OW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = 0; i < W; i++) code_o = code_o + OW'(therm_i[i]);
  end
endmodule

// File: rtl/hf_conv_seq.sv
module hf_conv_seq
  import hf_adc_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60,
  localparam int AW       = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NIB_W-1:0]  coarse_code_i,
  input  logic [NIB_W-1:0]  fine_code_i,
  output logic              busy_o,
  output logic              track_o,
  output logic              coarse_stb_o,
  output logic              fine_stb_o,
  output logic              done_o,
  output logic [NUM_CH-1:0] ch_sel_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int MAXC = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e             ph_q;
  logic [CW-1:0]      cnt_q;
  logic [NIB_W-1:0]   hi_q;
  logic [RES_W-1:0]   res_q;
  logic [NUM_CH-1:0]  ch_q;
  logic [NUM_CH-1:0]  ch_dec;
  logic               last;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign ch_dec[g] = (addr_i == AW'(g));
  end

  assign last         = (cnt_q == '0);
  assign busy_o       = (ph_q != PH_IDLE);
  assign track_o      = (ph_q == PH_TRACK);
  assign coarse_stb_o = (ph_q == PH_TRACK) && last;
  assign fine_stb_o   = (ph_q == PH_FINE) && last;
  assign done_o       = fine_stb_o;
  assign ch_sel_o     = ch_q;
  assign result_o     = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      hi_q  <= '0;
      res_q <= '0;
      ch_q  <= NUM_CH'(1);
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_TRACK;
          cnt_q <= CW'(TRACK_CYC - 1);
          ch_q  <= ch_dec;
        end
        PH_TRACK: if (last) begin
          hi_q  <= coarse_code_i;
          ph_q  <= PH_FINE;
          cnt_q <= CW'(FINE_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_FINE: if (last) begin
          res_q <= {hi_q, fine_code_i};
          ph_q  <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hf_adc_ctrl.sv
module hf_adc_ctrl
  import hf_adc_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60,
  localparam int AW       = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               mode1_i,
  input  logic [THERM_W-1:0] coarse_therm_i,
  input  logic [THERM_W-1:0] fine_therm_i,
  output logic [NUM_CH-1:0]  ch_sel_o,
  output logic               track_o,
  output logic               coarse_stb_o,
  output logic               fine_stb_o,
  output logic [RES_W-1:0]   data_o,
  output logic               data_oe_o,
  output logic               int_no,
  output logic               rdy_pull_o
);
  logic [NIB_W-1:0] coarse_code, fine_code;
  logic [RES_W-1:0] result;
  logic busy, done;
  logic cs_q, rd_q, seln_q;
  logic int_q, rdy_q, oe_q;
  logic sel_n, sel_fall, cs_fall, cs_rise, rd_rise, start;

  hf_therm_enc #(.W(THERM_W), .OW(NIB_W)) u_enc_coarse (
    .therm_i(coarse_therm_i), .code_o(coarse_code)
  );
  hf_therm_enc #(.W(THERM_W), .OW(NIB_W)) u_enc_fine (
    .therm_i(fine_therm_i), .code_o(fine_code)
  );

  assign sel_n    = cs_ni | rd_ni;
  assign sel_fall = !sel_n && seln_q;
  assign cs_fall  = !cs_ni && cs_q;
  assign cs_rise  = cs_ni && !cs_q;
  assign rd_rise  = rd_ni && !rd_q;
  assign start    = sel_fall && !busy;

  hf_conv_seq #(
    .NUM_CH(NUM_CH), .TRACK_CYC(TRACK_CYC), .FINE_CYC(FINE_CYC)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .addr_i        (addr_i),
    .coarse_code_i (coarse_code),
    .fine_code_i   (fine_code),
    .busy_o        (busy),
    .track_o       (track_o),
    .coarse_stb_o  (coarse_stb_o),
    .fine_stb_o    (fine_stb_o),
    .done_o        (done),
    .ch_sel_o      (ch_sel_o),
    .result_o      (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      seln_q <= 1'b1;
      int_q  <= 1'b1;
      rdy_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      rd_q   <= rd_ni;
      seln_q <= sel_n;
      if (done)                  int_q <= 1'b0;
      else if (cs_rise || rd_rise) int_q <= 1'b1;
      if (cs_fall)                            rdy_q <= 1'b1;
      else if (cs_rise || (!mode1_i && done)) rdy_q <= 1'b0;
      // stretched mode: drive only once the fresh result exists
      if (mode1_i) oe_q <= !sel_n;
      else         oe_q <= !sel_n && (done || oe_q);
    end
  end

  assign int_no     = int_q;
  assign rdy_pull_o = rdy_q;
  assign data_oe_o  = oe_q;
  assign data_o     = oe_q ? result : '0;
endmodule

// File: rtl/hf_adc_ctrl_chk.sv
module hf_adc_ctrl_chk
  import hf_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int AW    = $clog2(NUM_CH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               rd_ni,
  input logic [AW-1:0]      addr_i,
  input logic               mode1_i,
  input logic [THERM_W-1:0] coarse_therm_i,
  input logic [THERM_W-1:0] fine_therm_i,
  input logic [NUM_CH-1:0]  ch_sel_o,
  input logic               track_o,
  input logic               coarse_stb_o,
  input logic               fine_stb_o,
  input logic [RES_W-1:0]   data_o,
  input logic               data_oe_o,
  input logic               int_no,
  input logic               rdy_pull_o
);
  a_r1_onehot_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ch_sel_o));

  a_r2_coarse_in_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_stb_o |-> track_o);

  a_r2_fine_after_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_stb_o |-> !track_o && !coarse_stb_o);

  a_r2_coarse_then_fine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_stb_o |=> !track_o);

  a_r4_int_after_fine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_stb_o |=> !int_no);

  a_r4_int_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> $past(fine_stb_o));

  a_r5_rdy_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_pull_o) |-> !$past(cs_ni));

  a_r6_mode0_oe_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode1_i && data_oe_o) |-> !int_no);

  a_r7_mode1_oe_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_i && $past(mode1_i) && !$past(cs_ni) && !$past(rd_ni)) |-> data_oe_o);

  a_r8_ch_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_o && $past(track_o)) |-> $stable(ch_sel_o));
endmodule

bind hf_adc_ctrl hf_adc_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/hf_adc_ctrl_test.sv
module hf_adc_ctrl_test;
  localparam int NUM_CH = 8;
  localparam int AW     = 3;
  localparam int TRACK  = 100;
  localparam int FINE   = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cs_n = 1'b1, rd_n = 1'b1, mode1 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [14:0] coarse = '0, fine = '0;
  logic [NUM_CH-1:0] ch_sel;
  logic track, cstb, fstb, oe, int_n, rdy;
  logic [7:0] data;

  hf_adc_ctrl #(.NUM_CH(NUM_CH), .TRACK_CYC(TRACK), .FINE_CYC(FINE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .addr_i(addr),
    .mode1_i(mode1), .coarse_therm_i(coarse), .fine_therm_i(fine),
    .ch_sel_o(ch_sel), .track_o(track), .coarse_stb_o(cstb), .fine_stb_o(fstb),
    .data_o(data), .data_oe_o(oe), .int_no(int_n), .rdy_pull_o(rdy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] therm(input int n);
    return 15'((32'd1 << n) - 1);
  endfunction

  function automatic int ones(input logic [14:0] v);
    int c = 0;
    for (int i = 0; i < 15; i++) c += int'(v[i]);
    return c;
  endfunction

  // behavioural reference: elapsed-cycle count since start, -1 when idle
  int   m_el = -1;
  int   m_ch = 0;
  bit   m_int = 1, m_rdy = 0, m_oe = 0;
  int   m_hi = 0, m_res = 0;
  bit   p_sel = 0, p_cs = 1, p_rd = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_el = -1; m_ch = 0; m_int = 1; m_rdy = 0; m_oe = 0;
      m_hi = 0; m_res = 0; p_sel = 0; p_cs = 1; p_rd = 1;
    end else begin
      bit sel, done;
      sel  = !cs_n && !rd_n;
      done = 0;
      if (m_el >= 0) begin
        if (m_el == TRACK - 1) m_hi = ones(coarse);
        if (m_el == TRACK + FINE - 1) begin
          m_res = m_hi * 16 + ones(fine);
          done = 1;
          m_el = -1;
        end else m_el++;
      end else if (sel && !p_sel) begin
        m_el = 0;
        m_ch = int'(addr);
      end
      if (done) m_int = 0;
      else if ((cs_n && !p_cs) || (rd_n && !p_rd)) m_int = 1;
      if (!cs_n && p_cs) m_rdy = 1;
      else if ((cs_n && !p_cs) || (!mode1 && done)) m_rdy = 0;
      if (mode1) m_oe = sel;
      else m_oe = sel && (done || m_oe);
      p_sel = sel; p_cs = cs_n; p_rd = rd_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 track", 32'(track), 32'(m_el >= 0 && m_el < TRACK));
      chk("R2 coarse strobe", 32'(cstb), 32'(m_el == TRACK - 1));
      chk("R2 fine strobe", 32'(fstb), 32'(m_el == TRACK + FINE - 1));
      chk("R1 channel", 32'(ch_sel), 32'd1 << m_ch);
      chk("R4 int", 32'(int_n), 32'(m_int));
      chk("R5 rdy", 32'(rdy), 32'(m_rdy));
      chk(mode1 ? "R7 oe" : "R6 oe", 32'(oe), 32'(m_oe));
      chk("R3 R9 data", 32'(data), m_oe ? 32'(m_res) : 32'd0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stretched-mode conversion, chip select one cycle ahead of read
  task automatic m0_conv(input int a, input logic [14:0] c, input logic [14:0] f,
                         input int exp);
    addr = AW'(a); coarse = c; fine = f;
    cs_n = 1'b0;
    cyc(1);
    chk("R5 rdy on cs fall", 32'(rdy), 32'd1);
    rd_n = 1'b0;
    cyc(TRACK + FINE);
    chk("R6 bus quiet during conversion", 32'(oe), 32'd0);
    chk("R5 rdy held", 32'(rdy), 32'd1);
    cyc(1);
    chk("R6 result on bus", 32'(data), 32'(exp));
    chk("R4 int low at completion", 32'(int_n), 32'd0);
    chk("R5 rdy released mode0", 32'(rdy), 32'd0);
    chk("R1 latched channel", 32'(ch_sel), 32'd1 << a);
    cyc(2);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(2);
    chk("R4 int high after read rise", 32'(int_n), 32'd1);
    chk("R9 bus quiet after read", 32'(data), 32'd0);
  endtask

  task automatic m1_read(input int a, input logic [14:0] c, input logic [14:0] f,
                         input int prev);
    addr = AW'(a); coarse = c; fine = f;
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(2);
    chk("R7 previous result", 32'(data), 32'(prev));
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(2);
    chk("R5 rdy released on cs rise", 32'(rdy), 32'd0);
    chk("R7 oe off", 32'(oe), 32'd0);
    cyc(TRACK + FINE + 2);
  endtask

  task automatic run_all();
    cyc(2);
    chk("R9 reset int", 32'(int_n), 32'd1);
    chk("R9 reset rdy", 32'(rdy), 32'd0);
    chk("R9 reset oe", 32'(oe), 32'd0);
    chk("R9 reset data", 32'(data), 32'd0);
    chk("R9 reset track", 32'(track), 32'd0);
    chk("R9 reset channel", 32'(ch_sel), 32'd1);
    rst_n = 1'b1;
    cyc(3);

    m0_conv(2, therm(9), therm(5), 8'h95);
    m0_conv(7, 15'h5555, 15'h7FFF, 8'h8F);   // R3 bubble vector
    m0_conv(0, 15'h0000, 15'h0000, 8'h00);

    mode1 = 1'b1;
    cyc(2);
    m1_read(5, therm(15), therm(1), 8'h00);
    m1_read(1, therm(3), therm(12), 8'hF1);

    // R8: second read mid-conversion must not restart it
    addr = AW'(4); coarse = therm(6); fine = therm(10);
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(2);
    chk("R7 previous result", 32'(data), 32'h3C);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(40);
    addr = AW'(6);
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(2);
    chk("R8 read mid conversion shows old result", 32'(data), 32'h3C);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(TRACK + FINE - 44);
    chk("R8 not done early", 32'(int_n), 32'd1);
    chk("R8 channel kept", 32'(ch_sel), 32'd1 << 4);
    cyc(1);
    chk("R8 done at original time", 32'(int_n), 32'd0);
    cyc(3);
    m1_read(3, therm(0), therm(0), 8'h6A);
    cyc(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule